// File: doc/BRIEF.md
# PWM Input Activity Detector

This block supervises the two PWM drive inputs of a bridge-tied power stage, one input per half-bridge. It runs on a fast system clock, brings each input into the clock domain through a short flop chain and keeps a separate timer per input. The timer measures how long the input has held its present level. If either input keeps one level for longer than a timeout, the block flags that input as stuck. The same timer also measures the length of each low pulse. A low pulse shorter than the allowed minimum is flagged as an invalid frame in the cycle the pulse ends, with no timeout delay.

Any stuck or invalid-frame flag, from either input, drives the active-low shutdown line low one clock later. A fault manager elsewhere uses this line to put the output stage into high impedance. The fault is not latched. Once every input has again completed a full, valid frame (falling edge, low pulse of legal width, rising edge, next falling edge) after the last fault event, the shutdown line releases on its own. The timeout and the minimum low width are given in clock cycles. For example, a 13 µs timeout at 100 MHz is 1300 cycles, and a 50 ns minimum low time at 100 MHz is 5 cycles.

Top module: `pwm_activity_monitor`

## Requirements
- R1: While reset is asserted and directly after its release, shutdown_n_o is 1 and stuck_o and bad_frame_o are all 0.
- R2: While both inputs keep toggling, with every low pulse at least MIN_LOW_CYC clock samples long and every level held for fewer than TIMEOUT_CYC cycles, shutdown_n_o stays 1 and no flag is raised.
- R3: stuck_o[c] rises at the (TIMEOUT_CYC+3)-th rising clock edge after a change on pwm_i[c] (inputs sampled on rising edges), when pwm_i[c] then holds, whether it holds at 0 or at 1.
- R4: When pwm_i[c] rises after a low pulse of L clock samples, with a falling edge seen on that channel since its last fault, bad_frame_o[c] is a one-cycle pulse at the third rising edge after the rise if L < MIN_LOW_CYC, and stays 0 otherwise.
- R5: shutdown_n_o goes to 0 at the clock edge following any cycle in which any bit of stuck_o or bad_frame_o is 1, whichever channel raised it.
- R6: The shutdown is not latched. It releases only after every channel has completed a full valid frame (fall, legal low, rise, next fall) after the last fault event. One frame period of resumed activity on a formerly stuck channel is not enough.
- R7: A fault on one channel raises no stuck or invalid-frame flag on the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_i | input | NUM_CH | Raw PWM inputs, one per half-bridge |
| stuck_o | output | NUM_CH | Per-channel lost-activity flag (level held past the timeout) |
| bad_frame_o | output | NUM_CH | Per-channel one-cycle pulse for a low pulse that is too short |
| shutdown_n_o | output | 1 | Active-low shutdown request, 0 while any fault is pending |

## Verification
Three registers lie between a change on pwm_i and the block's view of it. An invalid low pulse therefore shows on bad_frame_o at the third rising edge after the rise was driven. A stuck flag appears TIMEOUT_CYC+3 edges after the last change, and shutdown_n_o follows either flag one edge later. The bench drives inputs on falling edges and notes the rising-edge count at each change it makes. A falling-edge monitor records the count at which each flag and the shutdown line move, and every latency check compares these two counts exactly. Release from shutdown is checked at frame boundaries: the line is still low after one resumed frame and high after two.

// File: rtl/pwmad_pkg.sv
package pwmad_pkg;

  // Progress of one channel through a PWM frame, used to qualify
  // short-pulse detection and to decide when a clean frame has passed.
  typedef enum logic [1:0] {
    FR_WAIT_FALL = 2'd0,
    FR_IN_LOW    = 2'd1,
    FR_IN_HIGH   = 2'd2
  } frame_st_e;

endpackage

// File: rtl/pwmad_sync.sv
module pwmad_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] lvl_dly_o
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] pipe_q [DEPTH];
  logic [W-1:0] pipe_d [DEPTH];

  always_comb begin
    pipe_d[0] = raw_i;
    for (int s = 1; s < DEPTH; s++) begin
      pipe_d[s] = pipe_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        pipe_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        pipe_q[s] <= pipe_d[s];
      end
    end
  end

  assign lvl_o     = pipe_q[STAGES-1];
  assign lvl_dly_o = pipe_q[STAGES];

endmodule

// File: rtl/pwmad_chan.sv
module pwmad_chan
  import pwmad_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1300,
  parameter int MIN_LOW_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic lvl_dly_i,
  output logic stuck_o,
  output logic bad_o,
  output logic frame_done_o
);

  localparam int            CW      = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LOW_LIM = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  frame_st_e     st_q, st_d;
  logic          bad_q, bad_d;
  logic          rise, fall, tog, stuck, short_low, done;

  assign rise  = lvl_i & ~lvl_dly_i;
  assign fall  = ~lvl_i & lvl_dly_i;
  assign tog   = rise | fall;
  assign stuck = (cnt_q == CNT_MAX);

  // One counter serves both as the quiet-time timer and, at a rising
  // edge, as the length of the low pulse just ended (length = cnt + 1).
  assign cnt_en = tog | ~stuck;
  assign cnt_d  = tog ? '0 : cnt_q + CW'(1);

  assign short_low = rise & (st_q == FR_IN_LOW) & (cnt_q < LOW_LIM);

  always_comb begin
    st_d = st_q;
    done = 1'b0;
    if (short_low) begin
      st_d = FR_WAIT_FALL;
    end else if (fall) begin
      done = (st_q == FR_IN_HIGH) & ~stuck;
      st_d = FR_IN_LOW;
    end else if (stuck) begin
      st_d = FR_WAIT_FALL;
    end else if (rise && st_q == FR_IN_LOW) begin
      st_d = FR_IN_HIGH;
    end
  end

  assign bad_d = short_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_WAIT_FALL;
      bad_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bad_q <= bad_d;
    end
  end

  assign stuck_o      = stuck;
  assign bad_o        = bad_q;
  assign frame_done_o = done;

endmodule

// File: rtl/pwmad_fault.sv
module pwmad_fault #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] stuck_i,
  input  logic [NUM_CH-1:0] bad_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic              shutdown_n_o
);

  logic [NUM_CH-1:0] good_q, good_d;
  logic              fault_q, fault_d;
  logic              event_now;

  assign event_now = (|stuck_i) | (|bad_i);

  // Every fault event wipes the per-channel clean-frame record, so
  // release waits for a fresh frame on each channel after the last one.
  always_comb begin
    good_d  = event_now ? '0 : (good_q | done_i);
    fault_d = fault_q;
    if (event_now) begin
      fault_d = 1'b1;
    end else if (&good_q) begin
      fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      good_q  <= good_d;
      fault_q <= fault_d;
    end
  end

  assign shutdown_n_o = ~fault_q;

endmodule

// File: rtl/pwm_activity_monitor.sv
module pwm_activity_monitor #(
  parameter int NUM_CH      = 2,
  parameter int TIMEOUT_CYC = 1300,
  parameter int MIN_LOW_CYC = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pwm_i,
  output logic [NUM_CH-1:0] stuck_o,
  output logic [NUM_CH-1:0] bad_frame_o,
  output logic              shutdown_n_o
);

  logic [NUM_CH-1:0] lvl, lvl_dly, done;

  pwmad_sync #(
    .W      (NUM_CH),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (pwm_i),
    .lvl_o     (lvl),
    .lvl_dly_o (lvl_dly)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmad_chan #(
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .MIN_LOW_CYC (MIN_LOW_CYC)
    ) chan_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .lvl_i        (lvl[c]),
      .lvl_dly_i    (lvl_dly[c]),
      .stuck_o      (stuck_o[c]),
      .bad_o        (bad_frame_o[c]),
      .frame_done_o (done[c])
    );
  end

  pwmad_fault #(
    .NUM_CH (NUM_CH)
  ) fault_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stuck_i      (stuck_o),
    .bad_i        (bad_frame_o),
    .done_i       (done),
    .shutdown_n_o (shutdown_n_o)
  );

endmodule

// File: rtl/pwm_activity_monitor_chk.sv
module pwm_activity_monitor_chk #(
  parameter int NUM_CH      = 2,
  parameter int TIMEOUT_CYC = 1300
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] stuck_o,
  input logic [NUM_CH-1:0] bad_frame_o,
  input logic              shutdown_n_o
);

  localparam int            RW     = $clog2(TIMEOUT_CYC + 4) + 1;
  localparam logic [RW-1:0] RAW_TO = RW'(TIMEOUT_CYC);
  localparam logic [RW-1:0] RAW_MX = {RW{1'b1}};

  logic [RW-1:0]     raw_cnt_q [NUM_CH];
  logic [NUM_CH-1:0] raw_prev_q;

  // Cycles since each raw input last changed, counted at the port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_prev_q <= '0;
      for (int c = 0; c < NUM_CH; c++) raw_cnt_q[c] <= '0;
    end else begin
      raw_prev_q <= pwm_i;
      for (int c = 0; c < NUM_CH; c++) begin
        if (pwm_i[c] != raw_prev_q[c]) raw_cnt_q[c] <= '0;
        else if (raw_cnt_q[c] != RAW_MX) raw_cnt_q[c] <= raw_cnt_q[c] + RW'(1);
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n === 1'b0 && !$isunknown({stuck_o, bad_frame_o, shutdown_n_o})) begin
      assert_reset_quiet_R1: assert (shutdown_n_o && stuck_o == '0 && bad_frame_o == '0)
        else $error("R1 outputs not quiet in reset");
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_stuck_after_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stuck_o[c]) |-> (raw_cnt_q[c] >= RAW_TO))
      else $error("R3 stuck flag before timeout");

    assert_bad_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_frame_o[c] |=> !bad_frame_o[c])
      else $error("R4 invalid-frame flag longer than one cycle");
  end

  assert_stuck_shuts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|stuck_o) |=> !shutdown_n_o)
    else $error("R5 no shutdown after stuck flag");

  assert_bad_shuts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|bad_frame_o) |=> !shutdown_n_o)
    else $error("R5 no shutdown after invalid frame");

  assert_clear_after_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_n_o) |-> (!$past(|stuck_o) && !$past(|bad_frame_o)))
    else $error("R6 release while a fault was present");

endmodule

bind pwm_activity_monitor pwm_activity_monitor_chk #(
  .NUM_CH      (NUM_CH),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_i        (pwm_i),
  .stuck_o      (stuck_o),
  .bad_frame_o  (bad_frame_o),
  .shutdown_n_o (shutdown_n_o)
);

// File: tb/pwm_activity_monitor_tb_top.sv
`timescale 1ns/1ps
module pwm_activity_monitor_tb_top;

  localparam int NCH = 2;
  localparam int TO  = 40;
  localparam int ML  = 4;
  localparam int FP  = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] pwm_r;
  logic [NCH-1:0] stuck_w, bad_w;
  logic           sd_n_w;

  always #2 clk = ~clk;

  pwm_activity_monitor #(
    .NUM_CH      (NCH),
    .TIMEOUT_CYC (TO),
    .MIN_LOW_CYC (ML),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_i        (pwm_r),
    .stuck_o      (stuck_w),
    .bad_frame_o  (bad_w),
    .shutdown_n_o (sd_n_w)
  );

  int tick = 0;
  int checks = 0;
  int fails = 0;
  int bad_cnt [NCH];
  int bad_tick [NCH];
  int stk_cnt [NCH];
  int stk_tick [NCH];
  int sd_fall_cnt = 0;
  int sd_fall_tick = 0;
  logic [NCH-1:0] stk_prev = '0;
  logic sd_prev = 1'b1;
  int last_chg [NCH];
  int last_rise [NCH];

  always @(posedge clk) tick <= tick + 1;

  initial begin
    for (int c = 0; c < NCH; c++) begin
      bad_cnt[c] = 0; bad_tick[c] = 0; stk_cnt[c] = 0; stk_tick[c] = 0;
      last_chg[c] = 0; last_rise[c] = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int c = 0; c < NCH; c++) begin
        if (bad_w[c]) begin
          bad_cnt[c]  = bad_cnt[c] + 1;
          bad_tick[c] = tick;
        end
        if (stuck_w[c] && !stk_prev[c]) begin
          stk_cnt[c]  = stk_cnt[c] + 1;
          stk_tick[c] = tick;
        end
        stk_prev[c] = stuck_w[c];
      end
      if (!sd_n_w && sd_prev) begin
        sd_fall_cnt  = sd_fall_cnt + 1;
        sd_fall_tick = tick;
      end
      sd_prev = sd_n_w;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // n frames of FP cycles; channel c is low for the first low_c cycles
  // of each frame unless held at a fixed level by hold_m/hold_v.
  task automatic frames(input int n, input int l0, input int l1,
                        input logic [NCH-1:0] hold_m, input logic [NCH-1:0] hold_v);
    for (int f = 0; f < n; f++) begin
      for (int p = 0; p < FP; p++) begin
        logic [NCH-1:0] nv;
        for (int c = 0; c < NCH; c++) begin
          int lw;
          lw = (c == 0) ? l0 : l1;
          nv[c] = hold_m[c] ? hold_v[c] : ((p >= lw) ? 1'b1 : 1'b0);
          if (nv[c] != pwm_r[c]) begin
            last_chg[c] = tick;
            if (nv[c]) last_rise[c] = tick;
          end
        end
        pwm_r = nv;
        @(negedge clk);
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int bs [NCH];
    int ss [NCH];
    int sds;
    rst_n = 1'b0;
    pwm_r = '0;
    repeat (3) @(negedge clk);
    chk("R1", "shutdown_n in reset", int'(sd_n_w), 1);
    chk("R1", "stuck in reset", int'(stuck_w), 0);
    chk("R1", "bad_frame in reset", int'(bad_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "shutdown_n after release", int'(sd_n_w), 1);
    chk("R1", "stuck after release", int'(stuck_w), 0);

    // R2: steady legal activity
    for (int c = 0; c < NCH; c++) begin bs[c] = bad_cnt[c]; ss[c] = stk_cnt[c]; end
    sds = sd_fall_cnt;
    frames(10, 5, 8, 2'b00, 2'b00);
    chk("R2", "bad count ch0", bad_cnt[0] - bs[0], 0);
    chk("R2", "bad count ch1", bad_cnt[1] - bs[1], 0);
    chk("R2", "stuck count", (stk_cnt[0] - ss[0]) + (stk_cnt[1] - ss[1]), 0);
    chk("R2", "shutdown falls", sd_fall_cnt - sds, 0);
    chk("R2", "shutdown_n level", int'(sd_n_w), 1);

    // R4/R5/R6/R7: low-width sweep on each channel
    for (int c = 0; c < NCH; c++) begin
      for (int l = 1; l <= ML + 2; l++) begin
        int rt;
        int expb;
        frames(2, 6, 6, 2'b00, 2'b00);
        for (int k = 0; k < NCH; k++) begin bs[k] = bad_cnt[k]; ss[k] = stk_cnt[k]; end
        sds = sd_fall_cnt;
        frames(1, (c == 0) ? l : 6, (c == 1) ? l : 6, 2'b00, 2'b00);
        rt = last_rise[c];
        frames(3, 6, 6, 2'b00, 2'b00);
        expb = (l < ML) ? 1 : 0;
        chk("R4", $sformatf("bad count ch%0d low=%0d", c, l), bad_cnt[c] - bs[c], expb);
        chk("R7", $sformatf("other bad ch%0d low=%0d", 1 - c, l), bad_cnt[1-c] - bs[1-c], 0);
        chk("R5", $sformatf("shutdown falls low=%0d", l), sd_fall_cnt - sds, expb);
        if (expb == 1) begin
          chk("R4", $sformatf("bad latency ch%0d low=%0d", c, l), bad_tick[c] - rt, 3);
          chk("R5", $sformatf("shutdown after bad ch%0d", c), sd_fall_tick - bad_tick[c], 1);
        end
        chk("R6", $sformatf("released ch%0d low=%0d", c, l), int'(sd_n_w), 1);
      end
    end

    // R3/R5/R6/R7: stuck at each level on each channel
    for (int c = 0; c < NCH; c++) begin
      for (int v = 0; v < 2; v++) begin
        int lc;
        logic [NCH-1:0] hm;
        frames(2, 6, 6, 2'b00, 2'b00);
        for (int k = 0; k < NCH; k++) begin bs[k] = bad_cnt[k]; ss[k] = stk_cnt[k]; end
        sds = sd_fall_cnt;
        hm = '0;
        hm[c] = 1'b1;
        frames(5, 6, 6, hm, (v == 1) ? 2'b11 : 2'b00);
        lc = last_chg[c];
        chk("R3", $sformatf("stuck count ch%0d lvl=%0d", c, v), stk_cnt[c] - ss[c], 1);
        chk("R3", $sformatf("stuck latency ch%0d lvl=%0d", c, v), stk_tick[c] - lc, TO + 3);
        chk("R7", $sformatf("other stuck ch%0d", 1 - c), stk_cnt[1-c] - ss[1-c], 0);
        chk("R7", $sformatf("no bad during stuck ch%0d", c),
            (bad_cnt[0] - bs[0]) + (bad_cnt[1] - bs[1]), 0);
        chk("R5", $sformatf("shutdown after stuck ch%0d lvl=%0d", c, v), sd_fall_tick - stk_tick[c], 1);
        frames(1, 6, 6, 2'b00, 2'b00);
        chk("R6", $sformatf("held after one frame ch%0d lvl=%0d", c, v), int'(sd_n_w), 0);
        frames(2, 6, 6, 2'b00, 2'b00);
        chk("R6", $sformatf("released ch%0d lvl=%0d", c, v), int'(sd_n_w), 1);
      end
    end

    summary();
    $finish;
  end

endmodule